// File: doc/BRIEF.md
# Front-Side Bus Request Packet Generator

This block sits between a processor core and a shared front-side bus and produces the request phase of each bus transaction. A core presents one memory or I/O request through a valid/ready handshake. The block checks the request and holds it until the bus grant input is high. It then sends two packets back to back over the same address pins and request-code pins. The first packet names the target and the kind of transaction. The second tells the other agents how the access behaves: its caching type, its length code and which bytes it touches.

The first packet carries physical address bits 35 to 3, giving a 36-bit address space aligned to 8 bytes. For I/O it carries the port number instead. The second packet carries a 3-bit memory-type attribute, a 2-bit length code and an 8-bit byte-enable mask. Write-back line transfers always enable all eight byte lanes. Uncacheable traffic goes out exactly as requested, partial-width enables included. A request that would reach the bus with no byte enabled, with the reserved length code, or with an undefined memory type is not sent. It is refused with a one-cycle error pulse.

Arbitration, snoop, response and data phases belong to other logic. Only the grant input is taken from arbitration.

Top module: `fsb_req_gen`

## Requirements
- R1: After synchronous reset, `req_ready` is 1. `bus_strobe`, `req_error`, `bus_addr` and `bus_req` are all 0.
- R2: Packet A is driven only in a cycle that follows a clock edge at which `bus_grant` was 1. While the grant stays low after a request is accepted, `bus_strobe` stays 0 and the pins stay 0. With the grant already high, packet A appears in the second cycle after the accepting edge.
- R3: For a memory request, packet A (the cycle with `bus_strobe`=1) drives `bus_addr` = `req_addr[35:3]` and `bus_req` = 01000 for a read or 01001 for a write.
- R4: For an I/O request, packet A drives `bus_addr` = `req_addr[15:0]`, zero-extended to 33 bits, and `bus_req` = 10000 for a read or 10001 for a write.
- R5: Packet B follows in the very next cycle with `bus_strobe`=0. It drives `bus_req[4:3]` = length code, `bus_req[2:0]` = memory type, `bus_addr[7:0]` = byte enables and `bus_addr[32:8]` = 0. The memory type encodings are UC=000, WC=001, WT=100, WP=101 and WB=110. The length codes are 00 for up to 8 bytes, 01 for 16 bytes and 11 for a 64-byte line; 10 is reserved.
- R6: A memory request with type WB and length 11 drives byte enables 11111111 in packet B, whatever `req_be` holds.
- R7: An I/O request drives memory type UC (000) in packet B, whatever `req_mtype` holds.
- R8: For every type other than a WB line, packet B drives `req_be` and the length code unchanged. `req_ready` is 0 from the cycle after acceptance through the cycle after packet B, and returns to 1 one cycle later.
- R9: A request is rejected when its effective byte enables are all zero, when its length code is 10, or when it is a memory request with an undefined memory type. On a rejected request, `req_error` is 1 in the cycle after the accepting edge only, `req_ready` stays 1, and no packet is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 36 | Physical byte address, or I/O port in bits 15:0 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_io | input | 1 | 1 for I/O space, 0 for memory |
| req_mtype | input | 3 | Memory type code |
| req_len | input | 2 | Length code |
| req_be | input | 8 | Byte-enable mask |
| bus_grant | input | 1 | Bus ownership granted |
| bus_addr | output | 33 | Multiplexed address pins |
| bus_req | output | 5 | Multiplexed request-code pins |
| bus_strobe | output | 1 | High during packet A |
| req_error | output | 1 | One-cycle pulse for a rejected request |

## Verification
A corrupted sequencer state shows at the ports within one cycle in one of three ways. A strobe may appear with no prior grant. Packet B may go missing after a strobe. Or `req_ready` may rise too early or stay low. Each is compared cycle by cycle against the fixed timing from the accepting edge. A wrong captured request or wrong packet selection shows in the two packet cycles as a misplaced address, a wrong request code, or a wrong attribute or enable field, most visibly on the WB-line and I/O overrides. A wrong validation decision shows in the next cycle as a missing or spurious error pulse and an unexpected strobe.

// File: rtl/fsbq_pkg.sv
package fsbq_pkg;

    parameter int ADDR_W    = 36;
    parameter int ALIGN_W   = 3;
    parameter int PIN_W     = ADDR_W - ALIGN_W;
    parameter int BE_W      = 8;
    parameter int PORT_W    = 16;
    parameter int LEN_W     = 2;
    parameter int MT_W      = 3;
    parameter int REQ_W     = LEN_W + MT_W;

    // memory type codes
    localparam logic [MT_W-1:0] MT_UC = 3'b000;
    localparam logic [MT_W-1:0] MT_WC = 3'b001;
    localparam logic [MT_W-1:0] MT_WT = 3'b100;
    localparam logic [MT_W-1:0] MT_WP = 3'b101;
    localparam logic [MT_W-1:0] MT_WB = 3'b110;

    // length codes
    localparam logic [LEN_W-1:0] LEN_8    = 2'b00;
    localparam logic [LEN_W-1:0] LEN_16   = 2'b01;
    localparam logic [LEN_W-1:0] LEN_RSVD = 2'b10;
    localparam logic [LEN_W-1:0] LEN_LINE = 2'b11;

    // request-type codes for packet A
    localparam logic [REQ_W-1:0] RT_MEM_RD = 5'b01000;
    localparam logic [REQ_W-1:0] RT_MEM_WR = 5'b01001;
    localparam logic [REQ_W-1:0] RT_IO_RD  = 5'b10000;
    localparam logic [REQ_W-1:0] RT_IO_WR  = 5'b10001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_PKA,
        ST_PKB,
        ST_REC
    } seq_state_e;

    typedef struct packed {
        logic [PIN_W-1:0] a_pins;
        logic [REQ_W-1:0] a_code;
        logic [PIN_W-1:0] b_pins;
        logic [REQ_W-1:0] b_code;
    } pkt_pair_t;

    function automatic logic mtype_known(input logic [MT_W-1:0] mt);
        return (mt == MT_UC) || (mt == MT_WC) || (mt == MT_WT) ||
               (mt == MT_WP) || (mt == MT_WB);
    endfunction

endpackage

// File: rtl/fsbq_decode.sv
module fsbq_decode
    import fsbq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              io,
    input  logic [MT_W-1:0]   mtype,
    input  logic [LEN_W-1:0]  len,
    input  logic [BE_W-1:0]   be,
    output logic              bad,
    output pkt_pair_t         pkt
);
    logic            line_fill;
    logic [BE_W-1:0] be_eff;
    logic [MT_W-1:0] attr;

    always_comb begin
        line_fill = !io && (mtype == MT_WB) && (len == LEN_LINE);
        be_eff    = line_fill ? {BE_W{1'b1}} : be;
        attr      = io ? MT_UC : mtype;

        bad = (be_eff == '0) || (len == LEN_RSVD) || (!io && !mtype_known(mtype));

        if (io) begin
            pkt.a_pins = PIN_W'(addr[PORT_W-1:0]);
            pkt.a_code = write ? RT_IO_WR : RT_IO_RD;
        end else begin
            pkt.a_pins = addr[ADDR_W-1:ALIGN_W];
            pkt.a_code = write ? RT_MEM_WR : RT_MEM_RD;
        end
        pkt.b_pins = PIN_W'(be_eff);
        pkt.b_code = {len, attr};
    end
endmodule

// File: rtl/fsbq_ctrl.sv
module fsbq_ctrl
    import fsbq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic bad,
    input  logic bus_grant,
    output logic req_ready,
    output logic load,
    output logic req_error,
    output logic phase_a,
    output logic phase_b
);
    seq_state_e state, state_nx;
    logic       accept;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign load      = accept && !bad;
    assign phase_a   = (state == ST_PKA);
    assign phase_b   = (state == ST_PKB);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (load)      state_nx = ST_ARB;
            ST_ARB:  if (bus_grant) state_nx = ST_PKA;
            ST_PKA:                 state_nx = ST_PKB;
            ST_PKB:                 state_nx = ST_REC;
            ST_REC:                 state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_error <= 1'b0;
        end else begin
            state     <= state_nx;
            req_error <= accept && bad;
        end
    end

    AST_STROBE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        phase_a |-> $past(bus_grant)); // R2
    AST_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
        phase_a |=> phase_b); // R5
    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        phase_b |=> !req_ready); // R8
    AST_ERR_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        req_error |-> (req_ready && !phase_a)); // R9
endmodule

// File: rtl/fsbq_drive.sv
module fsbq_drive
    import fsbq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  pkt_pair_t        pkt_in,
    input  logic             phase_a,
    input  logic             phase_b,
    output logic [PIN_W-1:0] bus_addr,
    output logic [REQ_W-1:0] bus_req,
    output logic             bus_strobe
);
    pkt_pair_t held;

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= pkt_in;
    end

    always_comb begin
        bus_strobe = phase_a;
        if (phase_a) begin
            bus_addr = held.a_pins;
            bus_req  = held.a_code;
        end else if (phase_b) begin
            bus_addr = held.b_pins;
            bus_req  = held.b_code;
        end else begin
            bus_addr = '0;
            bus_req  = '0;
        end
    end

    AST_B_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        phase_b |-> (bus_addr[BE_W-1:0] != '0)); // R9
    AST_B_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        phase_b |-> (bus_addr[PIN_W-1:BE_W] == '0)); // R5
endmodule

// File: rtl/fsb_req_gen.sv
module fsb_req_gen
    import fsbq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [MT_W-1:0]   req_mtype,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BE_W-1:0]   req_be,
    input  logic              bus_grant,
    output logic [PIN_W-1:0]  bus_addr,
    output logic [REQ_W-1:0]  bus_req,
    output logic              bus_strobe,
    output logic              req_error
);
    logic      bad, load, phase_a, phase_b;
    pkt_pair_t pkt;

    fsbq_decode u_decode (
        .addr(req_addr), .write(req_write), .io(req_io), .mtype(req_mtype),
        .len(req_len), .be(req_be), .bad(bad), .pkt(pkt)
    );

    fsbq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .bad(bad),
        .bus_grant(bus_grant), .req_ready(req_ready), .load(load),
        .req_error(req_error), .phase_a(phase_a), .phase_b(phase_b)
    );

    fsbq_drive u_drive (
        .clk(clk), .rst(rst), .load(load), .pkt_in(pkt), .phase_a(phase_a),
        .phase_b(phase_b), .bus_addr(bus_addr), .bus_req(bus_req),
        .bus_strobe(bus_strobe)
    );

    AST_STROBE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> (!req_ready && !req_error)); // R8
endmodule

// File: tb/fsb_req_gen_bench.sv
`timescale 1ns/1ps
module fsb_req_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_io, bus_grant;
    logic [35:0] req_addr;
    logic [2:0]  req_mtype;
    logic [1:0]  req_len;
    logic [7:0]  req_be;
    logic        req_ready, bus_strobe, req_error;
    logic [32:0] bus_addr;
    logic [4:0]  bus_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    fsb_req_gen u_fsb_req_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
        .req_mtype(req_mtype), .req_len(req_len), .req_be(req_be),
        .bus_grant(bus_grant), .bus_addr(bus_addr), .bus_req(bus_req),
        .bus_strobe(bus_strobe), .req_error(req_error)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // present a request at a negedge; it is accepted at the next posedge
    task automatic present(input logic [35:0] a, input logic w, input logic io,
                           input logic [2:0] mt, input logic [1:0] ln, input logic [7:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_io = io;
        req_mtype = mt; req_len = ln; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // grant already high: ARB now, then A, B, REC, IDLE
    task automatic expect_packets(input string tag, input logic [32:0] a_pins,
                                  input logic [4:0] a_code, input logic [7:0] be,
                                  input logic [4:0] b_code);
        chk({tag, " R8 ready low in arb"}, req_ready, 0);
        chk({tag, " R2 no strobe in arb"}, bus_strobe, 0);
        @(negedge clk);
        chk({tag, " R2 strobe A"}, bus_strobe, 1);
        chk({tag, " R3/R4 A addr"}, bus_addr, a_pins);
        chk({tag, " R3/R4 A code"}, bus_req, a_code);
        @(negedge clk);
        chk({tag, " R5 strobe low B"}, bus_strobe, 0);
        chk({tag, " R5 B pins"}, bus_addr, {25'd0, be});
        chk({tag, " R5 B code"}, bus_req, b_code);
        @(negedge clk);
        chk({tag, " R8 ready low after B"}, req_ready, 0);
        @(negedge clk);
        chk({tag, " R8 ready back"}, req_ready, 1);
    endtask

    task automatic t_reset;
        chk("R1 ready", req_ready, 1);
        chk("R1 strobe", bus_strobe, 0);
        chk("R1 error", req_error, 0);
        chk("R1 addr", bus_addr, 0);
        chk("R1 req", bus_req, 0);
    endtask

    task automatic t_wb_line;
        present(36'h8_1234_5678, 1'b0, 1'b0, 3'b110, 2'b11, 8'h0F);
        expect_packets("R6 WB line read", 33'h1_0246_8ACF, 5'b01000, 8'hFF, 5'b11110);
    endtask

    task automatic t_uc_partial;
        present(36'h9_8765_4328, 1'b1, 1'b0, 3'b000, 2'b00, 8'h30);
        expect_packets("R8 UC write", 33'h1_30EC_A865, 5'b01001, 8'h30, 5'b00000);
    endtask

    task automatic t_wc_16;
        present(36'h0_0000_0010, 1'b1, 1'b0, 3'b001, 2'b01, 8'hFF);
        expect_packets("R3 WC 16B", 33'h2, 5'b01001, 8'hFF, 5'b01001);
    endtask

    task automatic t_wp_line_be;
        // WP line keeps the enables as given
        present(36'hF_FFFF_FFF8, 1'b0, 1'b0, 3'b101, 2'b11, 8'h81);
        expect_packets("R8 WP line", 33'h1_FFFF_FFFF, 5'b01000, 8'h81, 5'b11101);
    endtask

    task automatic t_io;
        present(36'hA_BCDE_03F8, 1'b1, 1'b1, 3'b110, 2'b00, 8'h01);
        expect_packets("R4 R7 IO write", 33'h3F8, 5'b10001, 8'h01, 5'b00000);
        present(36'h0_0000_0060, 1'b0, 1'b1, 3'b100, 2'b00, 8'h03);
        expect_packets("R4 R7 IO read", 33'h60, 5'b10000, 8'h03, 5'b00000);
    endtask

    task automatic t_grant_wait;
        bus_grant = 1'b0;
        present(36'h1_0000_0040, 1'b0, 1'b0, 3'b100, 2'b00, 8'hFF);
        for (int i = 0; i < 5; i++) begin
            chk("R2 held without grant", {bus_strobe, bus_addr, bus_req}, 0);
            @(negedge clk);
        end
        bus_grant = 1'b1;
        chk("R2 still arb on raise", bus_strobe, 0);
        @(negedge clk);
        chk("R2 strobe after grant", bus_strobe, 1);
        chk("R3 addr after grant", bus_addr, 33'h2000_0008);
        @(negedge clk);
        chk("R5 B after grant", bus_req, 5'b00100);
        @(negedge clk);
        @(negedge clk);
        chk("R8 ready after grant wait", req_ready, 1);
    endtask

    task automatic expect_reject(input string tag);
        chk({tag, " R9 error pulse"}, req_error, 1);
        chk({tag, " R9 ready stays"}, req_ready, 1);
        chk({tag, " R9 no strobe"}, bus_strobe, 0);
        @(negedge clk);
        chk({tag, " R9 error ends"}, req_error, 0);
        chk({tag, " R9 still no strobe"}, bus_strobe, 0);
        @(negedge clk);
        chk({tag, " R9 quiet pins"}, {bus_strobe, bus_addr, bus_req}, 0);
    endtask

    task automatic t_reject;
        present(36'h2_0000_0000, 1'b1, 1'b0, 3'b000, 2'b00, 8'h00);
        expect_reject("zero be");
        present(36'h2_0000_0000, 1'b1, 1'b0, 3'b110, 2'b10, 8'hFF);
        expect_reject("reserved len");
        present(36'h2_0000_0000, 1'b0, 1'b0, 3'b010, 2'b00, 8'hFF);
        expect_reject("bad mtype");
        present(36'h0_0000_0080, 1'b0, 1'b1, 3'b000, 2'b00, 8'h00);
        expect_reject("io zero be");
        // WB line with zero enables is still legal
        present(36'h0_0000_0100, 1'b1, 1'b0, 3'b110, 2'b11, 8'h00);
        chk("R6 WB line zero be no error", req_error, 0);
        expect_packets("R6 WB line zero be", 33'h20, 5'b01001, 8'hFF, 5'b11110);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
        req_addr = '0; req_mtype = '0; req_len = '0; req_be = '0; bus_grant = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wb_line();
        t_uc_partial();
        t_wc_16();
        t_wp_line_be();
        t_io();
        t_grant_wait();
        t_reject();
        summary();
        $finish;
    end
endmodule